// File: doc/BRIEF.md
# Bit-Serial Dual-Register Activation × Weight Unit

This unit multiplies a signed weight by activations that arrive one bit per cycle, most significant bit first. The run time of one product is therefore set by a configurable precision p instead of the full operand width. Narrow layers finish in proportionally fewer cycles. Each lane has its own activation bit stream. All lanes share one weight and have separate partial-sum accumulators, so one weight serves several activations at the same time.

The weight sits in a working register that feeds the multiplier. That register can be loaded in two ways. In convolution mode it is loaded whole from a parallel input and then reused across as many products as needed. In fully-connected mode a separate staging register is filled one bit per cycle, and its contents are then copied into the working register. Both kinds of load may land on the cycle that consumes the last activation bit. The staging register may be refilled while products are running, so weight delivery overlaps computation.

Top module: `bitser_pe`

## Requirements
- R1: After reset every partial sum reads zero, `done` is low, and both weight registers hold zero, so a product run with no weight loaded gives zero.
- R2: When `mode_fc`=0, `br_load` copies `w_data` into the working weight at the clock edge. Without `br_load` the working weight is kept, and it is reused by every following product.
- R3: When `mode_fc`=1, each `ser_en` cycle shifts `ser_bit` into bit 0 of the staging register and moves the older bits one place toward the MSB. After WW shifts delivered MSB first, the register holds the weight. In this mode `br_load` copies the staging register into the working weight, and `w_data` is ignored.
- R4: When `mode_fc`=0, `ser_en` has no effect: the staging register keeps its contents.
- R5: Each accepted activation bit (one with `act_valid`=1) comes MSB first. Lane i takes its bit from `act_bits[i]`. When a product completes, the value added for lane i equals the working weight, read as two's complement WW bits, times that lane's activation value.
- R6: The precision is taken from `prec` on the first bit of a product. A value of 0, or one above PMAX, means PMAX. A product completes after exactly p accepted bits, and p=1 is allowed.
- R7: `act_signed` is sampled on the first bit. When it is 1, the activation is two's complement over p bits and its MSB weighs -2^(p-1). When it is 0, the activation is unsigned.
- R8: `done` is high for one cycle, in the cycle that follows the edge accepting the p-th bit. In that cycle the partial sums already include the new products. Products may run back to back with no idle cycle.
- R9: When a product completes, each partial sum takes its old value plus the new product. If `psum_clr` is high on that final cycle, the sum is the product alone. On any other cycle, `psum_clr` clears the sums to zero.
- R10: A cycle with `act_valid`=0 inside a product pauses it. The bit count and the running value hold, and the product resumes with the next accepted bit.
- R11: A weight load on the cycle of the last bit does not affect that bit: the last bit still uses the old weight. The new weight applies from the next product onward.
- R12: Each partial sum is 2·WW+4 bits wide and lane i occupies `psum[i*(2*WW+4) +: 2*WW+4]`. Adding a product never overflows the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_fc | input | 1 | 0: weight loads in parallel; 1: weight loads serially through the staging register |
| prec | input | $clog2(PMAX+1) | Activation precision p, sampled on the first bit |
| act_signed | input | 1 | Activation is two's complement, sampled on the first bit |
| w_data | input | WW | Parallel weight value |
| br_load | input | 1 | Load the working weight (source selected by mode) |
| ser_en | input | 1 | Shift one weight bit into the staging register |
| ser_bit | input | 1 | Serial weight bit |
| act_valid | input | 1 | Activation bits valid this cycle |
| act_bits | input | NACT | One activation bit per lane |
| psum_clr | input | 1 | Restart the partial sums |
| psum | output | NACT*(2*WW+4) | Partial sums, lane 0 in the low bits |
| done | output | 1 | One-cycle pulse when a product has been added |

## Verification
The hardest situation to create from the ports is the staging register filling in the background while products run, with the transfer into the working weight landing on a final activation bit. It has to match both the serial fill and the bit stream. The stimulus forks a 16-cycle serial shift alongside two products of 13 and 8 bits. The second product triggers the transfer on its last bit, and a third product checks that the new weight took effect exactly one product later. A second scenario shifts bits while the unit is in parallel mode, then switches to serial mode and transfers, which shows that the staging register was left untouched.

// File: rtl/bitser_pe_pkg.sv
package bitser_pe_pkg;

  typedef enum logic {
    MODE_CONV = 1'b0,
    MODE_FC   = 1'b1
  } pe_mode_e;

  // Signed addition overflows when both operands share a sign the result lacks.
  function automatic logic add_overflows(input logic a_msb, input logic b_msb,
                                         input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

endpackage

// File: rtl/bitser_wregs.sv
module bitser_wregs
  import bitser_pe_pkg::*;
#(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pe_mode_e      mode,
  input  logic          ser_en,
  input  logic          ser_bit,
  input  logic          br_load,
  input  logic [WW-1:0] w_data,
  output logic [WW-1:0] br_q
);

  logic [WW-1:0] ar_q;
  logic          ar_shift;
  logic [WW-1:0] br_src;

  assign ar_shift = (mode == MODE_FC) && ser_en;
  assign br_src   = (mode == MODE_FC) ? ar_q : w_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0;
      br_q <= '0;
    end else begin
      if (ar_shift) ar_q <= {ar_q[WW-2:0], ser_bit};
      if (br_load)  br_q <= br_src;
    end
  end

  AST_BR_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_load |=> $stable(br_q));                                   // R2
  AST_AR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CONV) |=> $stable(ar_q));                        // R4

endmodule

// File: rtl/bitser_seq.sv
module bitser_seq #(
  parameter int PMAX = 16,
  parameter int CW   = $clog2(PMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic [CW-1:0] prec,
  input  logic          act_signed,
  output logic          first_evt,
  output logic          last_evt,
  output logic          neg_evt
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] p_q;
  logic [CW-1:0] p_cur;

  function automatic logic [CW-1:0] eff_prec(input logic [CW-1:0] p);
    if (p == '0 || p > CW'(PMAX)) return CW'(PMAX);
    return p;
  endfunction

  assign first_evt = act_valid && (cnt_q == '0);
  assign p_cur     = first_evt ? eff_prec(prec) : p_q;
  assign last_evt  = act_valid && (cnt_q == p_cur - CW'(1));
  assign neg_evt   = first_evt && act_signed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      p_q   <= CW'(PMAX);
    end else if (act_valid) begin
      if (first_evt) p_q <= p_cur;
      cnt_q <= last_evt ? '0 : cnt_q + CW'(1);
    end
  end

  AST_CNT_BELOW_P: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < p_q));                              // R6
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> $stable(cnt_q));                                // R10

endmodule

// File: rtl/bitser_lane.sv
module bitser_lane
  import bitser_pe_pkg::*;
#(
  parameter int WW    = 16,
  parameter int ACC_W = 2 * WW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic             act_bit,
  input  logic             first_evt,
  input  logic             last_evt,
  input  logic             neg_evt,
  input  logic             psum_clr,
  input  logic [WW-1:0]    w,
  output logic [ACC_W-1:0] psum_q
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] sum_base;
  logic signed [ACC_W-1:0] sum_nxt;

  // One MSB-first step: double the running value, then add or subtract the gated weight.
  function automatic logic signed [ACC_W-1:0] shift_add(
      input logic signed [ACC_W-1:0] acc, input logic [WW-1:0] wt,
      input logic bit_in, input logic neg);
    logic signed [ACC_W-1:0] term;
    term = bit_in ? ACC_W'($signed(wt)) : '0;
    return (acc <<< 1) + (neg ? -term : term);
  endfunction

  assign acc_nxt  = shift_add(first_evt ? '0 : acc_q, w, act_bit, neg_evt);
  assign sum_base = psum_clr ? '0 : $signed(psum_q);
  assign sum_nxt  = sum_base + acc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      psum_q <= '0;
    end else begin
      if (act_valid) acc_q <= acc_nxt;
      if (last_evt)      psum_q <= sum_nxt;
      else if (psum_clr) psum_q <= '0;
    end
  end

  AST_PSUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psum_clr && !last_evt) |=> (psum_q == '0));                   // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |-> !add_overflows(sum_base[ACC_W-1], acc_nxt[ACC_W-1],
                                sum_nxt[ACC_W-1]));                // R12

endmodule

// File: rtl/bitser_pe.sv
module bitser_pe
  import bitser_pe_pkg::*;
#(
  parameter int WW   = 16,
  parameter int PMAX = 16,
  parameter int NACT = 2,
  localparam int ACC_W = 2 * WW + 4,
  localparam int CW    = $clog2(PMAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_fc,
  input  logic [CW-1:0]         prec,
  input  logic                  act_signed,
  input  logic [WW-1:0]         w_data,
  input  logic                  br_load,
  input  logic                  ser_en,
  input  logic                  ser_bit,
  input  logic                  act_valid,
  input  logic [NACT-1:0]       act_bits,
  input  logic                  psum_clr,
  output logic [NACT*ACC_W-1:0] psum,
  output logic                  done
);

  pe_mode_e      mode;
  logic [WW-1:0] br_w;
  logic          first_evt;
  logic          last_evt;
  logic          neg_evt;

  assign mode = mode_fc ? MODE_FC : MODE_CONV;

  bitser_wregs #(.WW(WW)) u_wregs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_en(ser_en), .ser_bit(ser_bit),
    .br_load(br_load), .w_data(w_data), .br_q(br_w)
  );

  bitser_seq #(.PMAX(PMAX), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .prec(prec),
    .act_signed(act_signed), .first_evt(first_evt), .last_evt(last_evt),
    .neg_evt(neg_evt)
  );

  for (genvar i = 0; i < NACT; i++) begin : g_lane
    bitser_lane #(.WW(WW), .ACC_W(ACC_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bit(act_bits[i]),
      .first_evt(first_evt), .last_evt(last_evt), .neg_evt(neg_evt),
      .psum_clr(psum_clr), .w(br_w), .psum_q(psum[i*ACC_W +: ACC_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last_evt;
  end

  AST_DONE_FOLLOWS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(act_valid));                                    // R8

endmodule

// File: tb/bitser_pe_test.sv
module bitser_pe_test;
  localparam int CLK_P = 10;
  localparam int WW = 16, PMAX = 16, NACT = 2;
  localparam int ACC_W = 2 * WW + 4;
  localparam int CW = $clog2(PMAX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_fc = 1'b0, act_signed = 1'b0, br_load = 1'b0;
  logic ser_en = 1'b0, ser_bit = 1'b0, act_valid = 1'b0, psum_clr = 1'b0;
  logic [CW-1:0] prec = '0;
  logic [WW-1:0] w_data = '0;
  logic [NACT-1:0] act_bits = '0;
  logic [NACT*ACC_W-1:0] psum;
  logic done;

  int total = 0, bad = 0;
  bit finished = 0;
  longint m_sum0 = 0, m_sum1 = 0;
  logic [WW-1:0] m_br = '0, m_ar = '0;
  longint q0[$], q1[$];
  string qt[$];

  bitser_pe #(.WW(WW), .PMAX(PMAX), .NACT(NACT)) uut (
    .clk(clk), .rst_n(rst_n), .mode_fc(mode_fc), .prec(prec),
    .act_signed(act_signed), .w_data(w_data), .br_load(br_load),
    .ser_en(ser_en), .ser_bit(ser_bit), .act_valid(act_valid),
    .act_bits(act_bits), .psum_clr(psum_clr), .psum(psum), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane_val(input int i);
    logic signed [ACC_W-1:0] v;
    v = psum[i*ACC_W +: ACC_W];
    return longint'(v);
  endfunction

  function automatic longint trunc(input longint e);
    logic signed [ACC_W-1:0] v;
    v = e[ACC_W-1:0];
    return longint'(v);
  endfunction

  // Monitor: the scoreboard pops one entry per done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q0.size() == 0) chk(0, "R8 unexpected done", 1, 0);
      else begin
        longint e0, e1;
        string t;
        e0 = q0.pop_front(); e1 = q1.pop_front(); t = qt.pop_front();
        chk(lane_val(0) == trunc(e0), {t, " lane0"}, lane_val(0), trunc(e0));
        chk(lane_val(1) == trunc(e1), {t, " lane1"}, lane_val(1), trunc(e1));
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    act_valid = 0; br_load = 0; psum_clr = 0; ser_en = 0;
  endtask

  task automatic set_mode(input logic fc);
    @(posedge clk); #1;
    act_valid = 0; br_load = 0; psum_clr = 0; mode_fc = fc;
  endtask

  task automatic load_w(input logic [WW-1:0] w);
    @(posedge clk); #1;
    act_valid = 0; psum_clr = 0; br_load = 1; w_data = w;
    m_br = mode_fc ? m_ar : w;
    @(posedge clk); #1; br_load = 0;
  endtask

  task automatic shift_ar(input logic [WW-1:0] w);
    for (int i = WW - 1; i >= 0; i--) begin
      @(posedge clk); #1;
      ser_en = 1; ser_bit = w[i];
      if (mode_fc) m_ar = {m_ar[WW-2:0], w[i]};
    end
    @(posedge clk); #1; ser_en = 0;
  endtask

  // Driver: streams the bits of one product, MSB first, and queues the expected sums.
  task automatic run_prod(input string tag, input logic [15:0] a0, input logic [15:0] a1,
                          input int pcfg, input bit sgn, input bit clr, input bit ld,
                          input logic [WW-1:0] w_next, input int stall_at);
    int pe;
    longint v0, v1, w;
    pe = (pcfg == 0 || pcfg > PMAX) ? PMAX : pcfg;
    v0 = 0; v1 = 0;
    for (int k = 0; k < pe; k++) begin
      v0 += longint'(a0[k]) << k;
      v1 += longint'(a1[k]) << k;
    end
    if (sgn && a0[pe-1]) v0 -= longint'(1) << pe;
    if (sgn && a1[pe-1]) v1 -= longint'(1) << pe;
    for (int i = pe - 1; i >= 0; i--) begin
      @(posedge clk); #1;
      act_valid = 1; prec = CW'(pcfg); act_signed = sgn;
      act_bits = {a1[i], a0[i]};
      psum_clr = clr && (i == pe - 1);
      br_load = ld && (i == 0); w_data = w_next;
      if (i == 0) begin
        w = longint'($signed(m_br));
        if (clr) begin m_sum0 = 0; m_sum1 = 0; end
        m_sum0 += w * v0; m_sum1 += w * v1;
        q0.push_back(m_sum0); q1.push_back(m_sum1); qt.push_back(tag);
        if (ld) m_br = mode_fc ? m_ar : w_next;
      end
      if (i == stall_at && i != 0) begin
        @(posedge clk); #1;
        act_valid = 0; psum_clr = 0; br_load = 0; act_bits = 2'b11;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    chk(lane_val(0) == 0, "R1 psum0 reset", lane_val(0), 0);
    chk(lane_val(1) == 0, "R1 psum1 reset", lane_val(1), 0);
    chk(done == 0, "R1 done reset", longint'(done), 0);
    rst_n = 1;
    // R1: working weight is zero out of reset
    run_prod("R1 zero weight", 16'd5, 16'd3, 4, 0, 1, 0, '0, -1);
    idle();
    // R2 R5: parallel weight, unsigned activations
    load_w(16'd100);
    run_prod("R5 unsigned p8", 16'd200, 16'd55, 8, 0, 1, 0, '0, -1);
    // R9 R11: accumulate, weight reloaded on last bit
    run_prod("R9 accumulate", 16'd3, 16'd7, 8, 0, 0, 1, 16'hFFF9, -1);
    // R7 R8 R11: back-to-back signed product uses -7
    run_prod("R7 signed p5", 16'h0010, 16'h000F, 5, 1, 1, 0, '0, -1);
    // R6: single-bit signed precision
    run_prod("R6 p1 signed", 16'h0001, 16'h0000, 1, 1, 1, 1, 16'h7FFF, -1);
    // R6: prec 0 means PMAX
    run_prod("R6 prec0 full", 16'h8001, 16'h7FFF, 0, 1, 1, 0, '0, -1);
    // R6: prec above PMAX clamps
    run_prod("R6 prec clamp", 16'hFFFF, 16'h1234, 20, 0, 1, 0, '0, -1);
    // R10: stalled stream
    run_prod("R10 stall", 16'd45, 16'd18, 6, 0, 1, 0, '0, 3);
    idle();
    // R9: clear outside a final bit
    @(posedge clk); #1; psum_clr = 1;
    @(posedge clk); #1; psum_clr = 0;
    @(negedge clk);
    chk(lane_val(0) == 0, "R9 clear psum0", lane_val(0), 0);
    chk(lane_val(1) == 0, "R9 clear psum1", lane_val(1), 0);
    m_sum0 = 0; m_sum1 = 0;
    // R3: serial staging then transfer, w_data ignored
    set_mode(1);
    shift_ar(16'hFFF3);
    load_w(16'h1234);
    run_prod("R3 serial weight", 16'd9, 16'h000D, 4, 1, 1, 0, '0, -1);
    // R11 R3: staging refill overlaps compute, transfer on last bit
    fork
      begin
        run_prod("R11 overlap a", 16'h1ABC, 16'h0F0F, 13, 1, 1, 0, '0, -1);
        run_prod("R11 overlap b", 16'd77, 16'd200, 8, 0, 0, 1, '0, -1);
      end
      shift_ar(16'd300);
    join
    run_prod("R11 new weight", 16'd11, 16'd6, 4, 0, 1, 0, '0, -1);
    // R4: shifting in parallel mode leaves the staging register alone
    set_mode(0);
    load_w(16'd5);
    shift_ar(16'd999);
    set_mode(1);
    load_w(16'h0000);
    run_prod("R4 staging kept", 16'd13, 16'd2, 5, 0, 1, 0, '0, -1);
    repeat (4) idle();
    // R8: every queued product produced exactly one done
    chk(q0.size() == 0, "R8 queue drained", q0.size(), 0);
    // R12: lane placement seen in the packed port
    chk(lane_val(1) == 300 * 2, "R12 lane1 field", lane_val(1), 600);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule